// File: doc/BRIEF.md
# Transmit Descriptor Pool Manager

This block holds a fixed pool of transmit descriptors that host software fills in to queue outgoing frames. Each descriptor is a 32-bit register at its own byte offset inside a small register window. It carries a frame length and a start bit. Software may take any free descriptor, in any order. When it writes the descriptor with the start bit set, it hands that slot to the transmit engine. The slot stays busy, and further writes to it are dropped, until the engine reports that the frame has gone out.

Because slots are started in arbitrary order rather than around a ring, the block records the order in which they were started in a small queue. It offers them to the transmit engine oldest first over a valid/ready request channel. The engine has at most one descriptor in flight at a time. A single-cycle done pulse from the engine frees that descriptor. A status word gives software a free mask and a flag that is set while every slot is busy, so software knows when it must wait.

Request channel rules: `tx_req_valid` rises only when at least one started descriptor is waiting and none is in flight. While it is high and `tx_req_ready` is low, the index and length stay constant. A cycle with both high hands the descriptor over. After that, valid stays low until `tx_done` releases that descriptor.

Top module: `txdesc_pool`

## Requirements
- R1: After reset every descriptor is free, the status word reads 0x0000000F, and `tx_req_valid` is low.
- R2: A write to descriptor offset 0x20+4*i (i = 0..3) of a free slot stores wr_data[15:0] as its length. If wr_data[31] is 1, it also marks the slot busy. A descriptor read returns {busy, 15'b0, length}.
- R3: A write with wr_data[31] = 0 to a free slot only updates its length: the slot stays free and no request is raised.
- R4: While a descriptor is busy, writes to it are dropped, and both its length and its start bit keep their values.
- R5: Busy descriptors are offered on `tx_req_idx`/`tx_req_len` in the order they were started, and only a busy slot is ever offered.
- R6: While `tx_req_valid` is high and `tx_req_ready` is low, valid, index and length hold from cycle to cycle.
- R7: Once a request is accepted, `tx_req_valid` stays low until `tx_done` releases that descriptor.
- R8: `tx_done` clears the start bit of the in-flight descriptor by the next cycle and leaves its length unchanged. `tx_done` with nothing in flight has no effect.
- R9: The status word at offset 0x30 carries the free mask in bits [3:0] (bit i = 1 when slot i is free) and a pool-exhausted flag in bit 8, set when all four slots are busy.
- R10: Offsets that are neither a descriptor nor the status word read as zero, and writes to them (or to the status word) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 8 | Byte offset of the write within the register window |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte offset of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| tx_req_valid | output | 1 | A started descriptor is offered to the engine |
| tx_req_ready | input | 1 | Engine accepts the offered descriptor |
| tx_req_idx | output | 2 | Index of the offered descriptor |
| tx_req_len | output | 16 | Frame length of the offered descriptor |
| tx_done | input | 1 | One-cycle pulse: the in-flight frame has been sent |

## Verification
The bench starts slots out of index order (1, 3, 0, 2) and checks that they are served in exactly that order. A design that picked by fixed priority would serve slot 0 first. The bench rewrites a busy slot with a different length and start bit, and a design that let the write through would report the new length when the frame is served. It holds ready low over several cycles to catch an index or length that drifts under back-pressure. It pulses done while nothing is in flight, which must not free the waiting slot. During the gap between acceptance and done it checks that valid stays low, because a design that offered the next slot early would have two frames outstanding. Finally it fills the pool to confirm the exhausted flag, and it reuses a slot after its release.

// File: rtl/txdp_pkg.sv
package txdp_pkg;
  // Bit positions inside the 32-bit register words
  localparam int START_BIT = 31;
  localparam int EXH_BIT   = 8;
  // Default byte offsets in the register window
  localparam logic [7:0] DESC_BASE_OFF = 8'h20;
  localparam logic [7:0] STATUS_OFF    = 8'h30;
endpackage

// File: rtl/txdp_desc_regs.sv
module txdp_desc_regs
  import txdp_pkg::*;
#(
  parameter int NUM_DESC = 4,
  parameter int LEN_W    = 16,
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] DESC_BASE = ADDR_W'(DESC_BASE_OFF),
  localparam int IDX_W   = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [LEN_W-1:0]          wr_len,
  input  logic                      wr_start,
  input  logic                      rel_en,
  input  logic [IDX_W-1:0]          rel_idx,
  output logic [NUM_DESC-1:0]       busy_o,
  output logic [NUM_DESC*LEN_W-1:0] len_o,
  output logic                      push_o,
  output logic [IDX_W-1:0]          push_idx_o
);

  logic [NUM_DESC-1:0] accept;

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT_ADDR = DESC_BASE + ADDR_W'(4 * g);
    logic             busy_q;
    logic [LEN_W-1:0] len_q;

    // A write lands only on a free slot
    assign accept[g] = wr_en && (wr_addr == SLOT_ADDR) && !busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_q <= 1'b0;
        len_q  <= '0;
      end else begin
        if (accept[g]) begin
          len_q <= wr_len;
          if (wr_start) busy_q <= 1'b1;
        end else if (rel_en && (rel_idx == IDX_W'(g))) begin
          busy_q <= 1'b0;
        end
      end
    end

    assign busy_o[g] = busy_q;
    assign len_o[g*LEN_W +: LEN_W] = len_q;
  end

  // At most one slot accepts per cycle (single write port)
  always_comb begin
    push_o     = 1'b0;
    push_idx_o = '0;
    for (int i = 0; i < NUM_DESC; i++) begin
      if (accept[i] && wr_start) begin
        push_o     = 1'b1;
        push_idx_o = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/txdp_order_q.sv
module txdp_order_q #(
  parameter int DEPTH = 4,
  parameter int IDX_W = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             pop,
  output logic [IDX_W-1:0] head,
  output logic             empty,
  output logic [CNT_W-1:0] count
);

  logic [IDX_W-1:0] slots_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      for (int i = 0; i < DEPTH; i++) slots_q[i] <= '0;
    end else begin
      if (push) begin
        slots_q[wr_ptr_q] <= push_idx;
        wr_ptr_q          <= bump(wr_ptr_q);
      end
      if (pop) rd_ptr_q <= bump(rd_ptr_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head  = slots_q[rd_ptr_q];
  assign empty = (cnt_q == '0);
  assign count = cnt_q;

endmodule

// File: rtl/txdp_dispatch.sv
module txdp_dispatch #(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q_empty,
  input  logic [IDX_W-1:0] q_head,
  output logic             q_pop,
  output logic             req_valid,
  input  logic             req_ready,
  input  logic             done,
  output logic             inflight,
  output logic [IDX_W-1:0] inflight_idx,
  output logic             rel_en,
  output logic [IDX_W-1:0] rel_idx
);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;

  assign req_valid = !q_empty && !busy_q;
  assign q_pop     = req_valid && req_ready;
  assign rel_en    = done && busy_q;
  assign rel_idx   = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (q_pop) begin
      busy_q <= 1'b1;
      idx_q  <= q_head;
    end else if (rel_en) begin
      busy_q <= 1'b0;
    end
  end

  assign inflight     = busy_q;
  assign inflight_idx = idx_q;

endmodule

// File: rtl/txdesc_pool.sv
module txdesc_pool
  import txdp_pkg::*;
#(
  parameter int NUM_DESC = 4,
  parameter int LEN_W    = 16,
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] DESC_BASE = ADDR_W'(DESC_BASE_OFF),
  parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STATUS_OFF),
  localparam int IDX_W   = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  localparam int CNT_W   = $clog2(NUM_DESC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              tx_req_valid,
  input  logic              tx_req_ready,
  output logic [IDX_W-1:0]  tx_req_idx,
  output logic [LEN_W-1:0]  tx_req_len,
  input  logic              tx_done
);

  logic [NUM_DESC-1:0]       busy;
  logic [NUM_DESC*LEN_W-1:0] len_flat;
  logic                      push, pop, q_empty, rel_en, inflight;
  logic [IDX_W-1:0]          push_idx, q_head, rel_idx, inflight_idx;
  logic [CNT_W-1:0]          q_count;
  logic                      unused_wr_bits;

  assign unused_wr_bits = ^wr_data[START_BIT-1:LEN_W];

  txdp_desc_regs #(
    .NUM_DESC(NUM_DESC), .LEN_W(LEN_W), .ADDR_W(ADDR_W), .DESC_BASE(DESC_BASE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_len(wr_data[LEN_W-1:0]), .wr_start(wr_data[START_BIT]),
    .rel_en(rel_en), .rel_idx(rel_idx),
    .busy_o(busy), .len_o(len_flat),
    .push_o(push), .push_idx_o(push_idx)
  );

  txdp_order_q #(.DEPTH(NUM_DESC), .IDX_W(IDX_W)) u_order (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_idx(push_idx), .pop(pop),
    .head(q_head), .empty(q_empty), .count(q_count)
  );

  txdp_dispatch #(.IDX_W(IDX_W)) u_disp (
    .clk(clk), .rst_n(rst_n),
    .q_empty(q_empty), .q_head(q_head), .q_pop(pop),
    .req_valid(tx_req_valid), .req_ready(tx_req_ready), .done(tx_done),
    .inflight(inflight), .inflight_idx(inflight_idx),
    .rel_en(rel_en), .rel_idx(rel_idx)
  );

  assign tx_req_idx = q_head;
  assign tx_req_len = len_flat[q_head*LEN_W +: LEN_W];

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_DESC; i++) begin
      if (rd_addr == DESC_BASE + ADDR_W'(4 * i)) begin
        rd_data[LEN_W-1:0] = len_flat[i*LEN_W +: LEN_W];
        rd_data[START_BIT] = busy[i];
      end
    end
    if (rd_addr == STAT_ADDR) begin
      rd_data[NUM_DESC-1:0] = ~busy;
      rd_data[EXH_BIT]      = &busy;
    end
  end

endmodule

// File: rtl/txdp_chk.sv
module txdp_chk #(
  parameter int NUM_DESC = 4,
  parameter int LEN_W    = 16,
  parameter int IDX_W    = 2,
  parameter int CNT_W    = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      tx_req_valid,
  input logic                      tx_req_ready,
  input logic [IDX_W-1:0]          tx_req_idx,
  input logic [LEN_W-1:0]          tx_req_len,
  input logic                      tx_done,
  input logic [NUM_DESC-1:0]       busy,
  input logic [NUM_DESC*LEN_W-1:0] len_flat,
  input logic                      inflight,
  input logic [IDX_W-1:0]          inflight_idx,
  input logic [CNT_W-1:0]          q_count
);

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_valid && !tx_req_ready |=>
      tx_req_valid && $stable(tx_req_idx) && $stable(tx_req_len));

  // R7
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_valid && tx_req_ready |=> !tx_req_valid);

  // R5
  offer_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_valid |-> busy[tx_req_idx]);

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done && inflight |=> !busy[$past(inflight_idx)]);

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CNT_W'(NUM_DESC));

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_len
    // R4
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy[g] |=> $stable(len_flat[g*LEN_W +: LEN_W]));
  end

endmodule

bind txdesc_pool txdp_chk #(
  .NUM_DESC(NUM_DESC), .LEN_W(LEN_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .tx_req_valid(tx_req_valid), .tx_req_ready(tx_req_ready),
  .tx_req_idx(tx_req_idx), .tx_req_len(tx_req_len), .tx_done(tx_done),
  .busy(busy), .len_flat(len_flat),
  .inflight(inflight), .inflight_idx(inflight_idx), .q_count(q_count)
);

// File: tb/txdesc_pool_tb.sv
module txdesc_pool_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        tx_req_valid;
  logic        tx_req_ready = 1'b0;
  logic [1:0]  tx_req_idx;
  logic [15:0] tx_req_len;
  logic        tx_done = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  txdesc_pool u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .tx_req_valid(tx_req_valid), .tx_req_ready(tx_req_ready),
    .tx_req_idx(tx_req_idx), .tx_req_len(tx_req_len),
    .tx_done(tx_done)
  );

  // {write offset, write data, read offset, expected read data}
  localparam logic [79:0] VEC [8] = '{
    {8'h24, 32'h0000_0040, 8'h24, 32'h0000_0040},  // R3 length only
    {8'h30, 32'hFFFF_FFFF, 8'h30, 32'h0000_000F},  // R10 status not writable
    {8'h24, 32'h8000_0100, 8'h24, 32'h8000_0100},  // R2 start slot 1
    {8'h24, 32'h8000_0222, 8'h24, 32'h8000_0100},  // R4 busy write dropped
    {8'h2C, 32'h8000_0333, 8'h2C, 32'h8000_0333},  // R2 start slot 3
    {8'h20, 32'h8000_0044, 8'h20, 32'h8000_0044},  // R2 start slot 0
    {8'h34, 32'h8000_0055, 8'h34, 32'h0000_0000},  // R10 unmapped offset
    {8'h28, 32'h8000_0066, 8'h30, 32'h0000_0100}   // R9 pool exhausted
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_check(input logic [7:0] a, input logic [31:0] exp,
                           input string tag);
    rd_addr = a;
    #1;
    check(rd_data === exp, tag, rd_data, exp);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    logic [1:0]  exp_idx [4];
    logic [15:0] exp_len [4];
    exp_idx = '{2'd1, 2'd3, 2'd0, 2'd2};
    exp_len = '{16'h0100, 16'h0333, 16'h0044, 16'h0066};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_check(8'h30, 32'h0000_000F, "R1 status after reset");
    check(tx_req_valid === 1'b0, "R1 valid after reset", 32'(tx_req_valid), 0);

    // Table walk, engine not ready
    for (int v = 0; v < 8; v++) begin
      reg_write(VEC[v][79:72], VEC[v][71:40]);
      reg_check(VEC[v][39:32], VEC[v][31:0],
                $sformatf("table vector %0d (R2 R3 R4 R9 R10)", v));
    end

    // R6 hold under back-pressure
    for (int c = 0; c < 3; c++) begin
      check(tx_req_valid === 1'b1 && tx_req_idx === 2'd1 && tx_req_len === 16'h0100,
            "R6 request held while not ready", {14'd0, tx_req_idx, tx_req_len},
            {16'h0001, 16'h0100});
      @(negedge clk);
    end

    // R8 done with nothing in flight is ignored
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
    reg_check(8'h30, 32'h0000_0100, "R8 stray done ignored");

    // R5 start order, R7 single outstanding, R8 release
    for (int k = 0; k < 4; k++) begin
      check(tx_req_valid === 1'b1 && tx_req_idx === exp_idx[k] &&
            tx_req_len === exp_len[k], "R5 served in start order",
            {14'd0, tx_req_idx, tx_req_len}, {14'd0, exp_idx[k], exp_len[k]});
      tx_req_ready = 1'b1;
      @(negedge clk);
      tx_req_ready = 1'b0;
      for (int c = 0; c < 3; c++) begin
        check(tx_req_valid === 1'b0, "R7 valid low while in flight",
              32'(tx_req_valid), 0);
        @(negedge clk);
      end
      reg_check(8'h20 + 8'(4 * exp_idx[k]), {1'b1, 15'd0, exp_len[k]},
                "R8 busy until done");
      tx_done = 1'b1;
      @(negedge clk);
      tx_done = 1'b0;
      reg_check(8'h20 + 8'(4 * exp_idx[k]), {16'd0, exp_len[k]},
                "R8 released by done");
    end

    check(tx_req_valid === 1'b0, "R5 nothing left to serve", 32'(tx_req_valid), 0);
    reg_check(8'h30, 32'h0000_000F, "R9 all free again");

    // R2 reuse a released slot
    reg_write(8'h28, 32'h8000_0777);
    check(tx_req_valid === 1'b1 && tx_req_idx === 2'd2 && tx_req_len === 16'h0777,
          "R2 reused slot offered", {14'd0, tx_req_idx, tx_req_len},
          {16'h0002, 16'h0777});
    reg_check(8'h30, 32'h0000_000B, "R9 mask with slot 2 busy");

    // R1 reset while busy
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reg_check(8'h30, 32'h0000_000F, "R1 status after second reset");
    reg_check(8'h28, 32'h0000_0000, "R1 descriptor cleared by reset");
    check(tx_req_valid === 1'b0, "R1 valid after second reset", 32'(tx_req_valid), 0);

    finished = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule